// File: doc/BRIEF.md
# Clock Generator Power Sequencer with Strap Capture

This block controls how a clock generator comes up and goes down. When power-on reset is released it samples the configuration straps, which share pads with clock outputs. It holds the sampled levels in a register that is written once, and then hands those pads over to clock driving. After that capture it runs the same power-up path used on every power-down exit. The crystal oscillator is enabled first and given a settle time. Then the VCO is enabled, and the block waits for lock or for a timeout before it releases the clock outputs.

An active-low power-down request arrives asynchronously and passes through a synchronizer. The first falling clock edge after the synchronized request goes low gates every clock output off. The outputs stay low for a hold period so that the slower reference outputs can finish their cycle. The VCO is switched off next, and the crystal after it. While power-down is in progress, the CPU and PCI stop requests have no effect. The analog oscillator and PLL are outside the block and are seen only through the enable outputs and a lock input.

States:
- `ST_LATCH`: the reset state; it captures the straps.
- `ST_XTAL_ON`: the crystal settles.
- `ST_VCO_ON`: the VCO is enabled.
- `ST_WAIT_STABLE`: the block waits for lock or timeout.
- `ST_RUN`: the clocks are released.
- `ST_OUT_LOW`: the outputs are held low.
- `ST_VCO_OFF`: the VCO is switched off.
- `ST_XTAL_OFF`: the block stays powered down.

Transitions:
- LATCH→XTAL_ON on the first edge.
- XTAL_ON→VCO_ON after XTAL_SETTLE cycles.
- VCO_ON→WAIT_STABLE after one cycle.
- WAIT_STABLE→RUN on lock or after LOCK_TMO cycles.
- RUN→OUT_LOW on a synchronized request.
- OUT_LOW→VCO_OFF after LOW_HOLD cycles.
- VCO_OFF→XTAL_OFF after one cycle.
- XTAL_OFF→XTAL_ON when the request is removed.

Top module: `clkgen_pwr_seq`

## Requirements
- R1: The first rising edge after power-on reset is released loads `strap_pad` into `strap_q` and raises `pad_drive_en`. Before that edge, `pad_drive_en` is 0.
- R2: Once `pad_drive_en` is 1, `strap_q` never changes again until the next power-on reset. Pad changes and power-down exits do not resample it.
- R3: While reset is held, `xtal_en`, `vco_en`, `all_clk_en`, `cpu_clk_en` and `pci_clk_en` are all 0.
- R4: `pd_n` passes through two synchronizing stages. Once it is low, all three clock enables drop at the falling edge after the second rising edge. After only one rising edge they are unchanged.
- R5: After the outputs are gated, `vco_en` and `xtal_en` stay 1 for LOW_HOLD+1 more rising edges. Then `vco_en` drops, and `xtal_en` drops one edge later. `vco_en` is never 1 while `xtal_en` is 0.
- R6: From the moment power-down is requested until the clocks are released again, all clock enables stay 0 whatever `cpu_stop_n` and `pci_stop_n` do.
- R7: In RUN, `cpu_clk_en` follows `cpu_stop_n` and `pci_clk_en` follows `pci_stop_n`, each with the R4 latency, while `all_clk_en` stays 1.
- R8: After `pd_n` returns high in XTAL_OFF, `xtal_en` rises on the third rising edge. `vco_en` rises XTAL_SETTLE edges after that.
- R9: When the synchronized lock is 1, the clock enables return one cycle after WAIT_STABLE is entered, at the following falling edge.
- R10: Without lock, WAIT_STABLE lasts exactly LOCK_TMO cycles before RUN.
- R11: After power-on reset, the block passes through XTAL_ON, VCO_ON and WAIT_STABLE with the same timing as a power-down exit before it reaches RUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal CPU-domain reference clock |
| rst_n | input | 1 | Power-on reset, asynchronous, active low |
| pd_n | input | 1 | Power-down request, asynchronous, active low |
| cpu_stop_n | input | 1 | CPU clock stop request, asynchronous, active low |
| pci_stop_n | input | 1 | PCI clock stop request, asynchronous, active low |
| vco_lock | input | 1 | PLL lock indication, asynchronous |
| strap_pad | input | STRAP_W | Pad levels sampled as configuration straps |
| strap_q | output | STRAP_W | Captured strap value |
| pad_drive_en | output | 1 | Shared pads switched to clock output mode |
| xtal_en | output | 1 | Crystal oscillator enable |
| vco_en | output | 1 | VCO enable |
| all_clk_en | output | 1 | Enable for all clock outputs (low means held low) |
| cpu_clk_en | output | 1 | Enable for the CPU clock outputs |
| pci_clk_en | output | 1 | Enable for the stoppable PCI outputs |

## Verification
The bench builds the block with STRAP_W=5, LOW_HOLD=3, XTAL_SETTLE=5 and LOCK_TMO=20. These short windows let it count every state dwell edge by edge and still finish quickly. With only 5 strap bits it can cycle power-on reset through all 32 strap values, and it checks the whole power-up path each time. It also steps both stop inputs through all four combinations in RUN and again while powered down. Both ways out of WAIT_STABLE are covered: by lock, and by a timeout that takes exactly 20 cycles.

// File: rtl/clkseq_pkg.sv
package clkseq_pkg;

    typedef enum logic [2:0] {
        ST_LATCH,
        ST_RUN,
        ST_OUT_LOW,
        ST_VCO_OFF,
        ST_XTAL_OFF,
        ST_XTAL_ON,
        ST_VCO_ON,
        ST_WAIT_STABLE
    } seq_state_e;

endpackage

// File: rtl/clkseq_sync.sv
module clkseq_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] stg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg <= '0;
        end else begin
            stg <= {stg[STAGES-2:0], d};
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/clkseq_strap_latch.sv
module clkseq_strap_latch #(
    parameter int WIDTH = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic [WIDTH-1:0] pad_i,
    output logic [WIDTH-1:0] strap_q,
    output logic             valid
);

    // Written once per power-on reset; valid blocks any later load.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strap_q <= '0;
            valid   <= 1'b0;
        end else if (capture && !valid) begin
            strap_q <= pad_i;
            valid   <= 1'b1;
        end
    end

endmodule

// File: rtl/clkseq_fsm.sv
module clkseq_fsm
    import clkseq_pkg::*;
#(
    parameter int LOW_HOLD    = 4,
    parameter int XTAL_SETTLE = 16,
    parameter int LOCK_TMO    = 40000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pd_ok,
    input  logic lock_ok,
    output logic capture,
    output logic run,
    output logic vco_en,
    output logic xtal_en
);

    localparam int TOP_A   = (LOW_HOLD > XTAL_SETTLE) ? LOW_HOLD : XTAL_SETTLE;
    localparam int CNT_TOP = (TOP_A > LOCK_TMO) ? TOP_A : LOCK_TMO;
    localparam int CW      = $clog2(CNT_TOP + 1);

    localparam logic [CW-1:0] HOLD_LAST   = CW'(LOW_HOLD - 1);
    localparam logic [CW-1:0] SETTLE_LAST = CW'(XTAL_SETTLE - 1);
    localparam logic [CW-1:0] TMO_LAST    = CW'(LOCK_TMO - 1);

    seq_state_e    state, state_n;
    logic [CW-1:0] cnt, cnt_n;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_LATCH;
            cnt   <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
        end
    end

    // Next state and dwell counter
    always_comb begin
        state_n = state;
        cnt_n   = cnt + 1'b1;
        unique case (state)
            ST_LATCH: begin
                state_n = ST_XTAL_ON;
                cnt_n   = '0;
            end
            ST_RUN: begin
                cnt_n = '0;
                if (!pd_ok) state_n = ST_OUT_LOW;
            end
            ST_OUT_LOW: begin
                if (cnt == HOLD_LAST) begin
                    state_n = ST_VCO_OFF;
                    cnt_n   = '0;
                end
            end
            ST_VCO_OFF: begin
                state_n = ST_XTAL_OFF;
                cnt_n   = '0;
            end
            ST_XTAL_OFF: begin
                cnt_n = '0;
                if (pd_ok) state_n = ST_XTAL_ON;
            end
            ST_XTAL_ON: begin
                if (cnt == SETTLE_LAST) begin
                    state_n = ST_VCO_ON;
                    cnt_n   = '0;
                end
            end
            ST_VCO_ON: begin
                state_n = ST_WAIT_STABLE;
                cnt_n   = '0;
            end
            ST_WAIT_STABLE: begin
                if (lock_ok || cnt == TMO_LAST) begin
                    state_n = ST_RUN;
                    cnt_n   = '0;
                end
            end
            default: begin
                state_n = ST_LATCH;
                cnt_n   = '0;
            end
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        capture = (state == ST_LATCH);
        run     = (state == ST_RUN);
        vco_en  = state inside {ST_RUN, ST_OUT_LOW, ST_VCO_ON, ST_WAIT_STABLE};
        xtal_en = state inside {ST_RUN, ST_OUT_LOW, ST_VCO_OFF,
                                ST_XTAL_ON, ST_VCO_ON, ST_WAIT_STABLE};
    end

endmodule

// File: rtl/clkseq_gate.sv
module clkseq_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic pd_ok,
    input  logic cpu_ok,
    input  logic pci_ok,
    output logic all_en,
    output logic cpu_en,
    output logic pci_en
);

    logic all_d;

    // Using pd_ok directly cuts the outputs on the falling edge that
    // follows the synchronized request, one cycle ahead of the FSM.
    assign all_d = run & pd_ok;

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            all_en <= 1'b0;
            cpu_en <= 1'b0;
            pci_en <= 1'b0;
        end else begin
            all_en <= all_d;
            cpu_en <= all_d & cpu_ok;
            pci_en <= all_d & pci_ok;
        end
    end

endmodule

// File: rtl/clkgen_pwr_seq.sv
module clkgen_pwr_seq #(
    parameter int STRAP_W     = 5,
    parameter int LOW_HOLD    = 4,
    parameter int XTAL_SETTLE = 16,
    parameter int LOCK_TMO    = 40000,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pd_n,
    input  logic               cpu_stop_n,
    input  logic               pci_stop_n,
    input  logic               vco_lock,
    input  logic [STRAP_W-1:0] strap_pad,
    output logic [STRAP_W-1:0] strap_q,
    output logic               pad_drive_en,
    output logic               xtal_en,
    output logic               vco_en,
    output logic               all_clk_en,
    output logic               cpu_clk_en,
    output logic               pci_clk_en
);

    localparam int NSYNC = 4;

    logic [NSYNC-1:0] async_in, sync_out;
    logic             pd_ok, lock_ok, cpu_ok, pci_ok;
    logic             capture, run;

    assign async_in = {pd_n, vco_lock, cpu_stop_n, pci_stop_n};
    assign {pd_ok, lock_ok, cpu_ok, pci_ok} = sync_out;

    clkseq_sync #(.WIDTH(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (async_in),
        .q     (sync_out)
    );

    clkseq_fsm #(
        .LOW_HOLD    (LOW_HOLD),
        .XTAL_SETTLE (XTAL_SETTLE),
        .LOCK_TMO    (LOCK_TMO)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .pd_ok   (pd_ok),
        .lock_ok (lock_ok),
        .capture (capture),
        .run     (run),
        .vco_en  (vco_en),
        .xtal_en (xtal_en)
    );

    clkseq_strap_latch #(.WIDTH(STRAP_W)) u_strap (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .pad_i   (strap_pad),
        .strap_q (strap_q),
        .valid   (pad_drive_en)
    );

    clkseq_gate u_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .pd_ok  (pd_ok),
        .cpu_ok (cpu_ok),
        .pci_ok (pci_ok),
        .all_en (all_clk_en),
        .cpu_en (cpu_clk_en),
        .pci_en (pci_clk_en)
    );

endmodule

// File: rtl/clkgen_pwr_seq_chk.sv
module clkgen_pwr_seq_chk #(
    parameter int STRAP_W = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic [STRAP_W-1:0] strap_q,
    input logic               pad_drive_en,
    input logic               xtal_en,
    input logic               vco_en,
    input logic               all_clk_en,
    input logic               cpu_clk_en,
    input logic               pci_clk_en
);

    // R5: VCO is never on without the crystal
    a_r5_vco_needs_xtal: assert property (@(posedge clk) disable iff (!rst_n)
        vco_en |-> xtal_en);

    // R4: clocks are only released while the VCO runs
    a_r4_clk_needs_vco: assert property (@(posedge clk) disable iff (!rst_n)
        all_clk_en |-> vco_en);

    // R6: the stoppable groups never run while all outputs are held low
    a_r6_cpu_within_all: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_clk_en |-> all_clk_en);

    a_r6_pci_within_all: assert property (@(posedge clk) disable iff (!rst_n)
        pci_clk_en |-> all_clk_en);

    // R2: the strap capture is frozen once the pads drive clocks
    a_r2_strap_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        pad_drive_en |=> (pad_drive_en && $stable(strap_q)));

    // R8: VCO turns on only after the crystal was already running
    a_r8_vco_after_xtal: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vco_en) |-> $past(xtal_en));

endmodule

bind clkgen_pwr_seq clkgen_pwr_seq_chk #(.STRAP_W(STRAP_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .strap_q      (strap_q),
    .pad_drive_en (pad_drive_en),
    .xtal_en      (xtal_en),
    .vco_en       (vco_en),
    .all_clk_en   (all_clk_en),
    .cpu_clk_en   (cpu_clk_en),
    .pci_clk_en   (pci_clk_en)
);

// File: tb/clkgen_pwr_seq_test.sv
module clkgen_pwr_seq_test;

    localparam int SW  = 5;
    localparam int LH  = 3;
    localparam int XS  = 5;
    localparam int TMO = 20;

    logic          clk = 1'b0;
    logic          rst_n, pd_n, cpu_stop_n, pci_stop_n, vco_lock;
    logic [SW-1:0] strap_pad, strap_q;
    logic          pad_drive_en, xtal_en, vco_en;
    logic          all_clk_en, cpu_clk_en, pci_clk_en;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    clkgen_pwr_seq #(
        .STRAP_W(SW), .LOW_HOLD(LH), .XTAL_SETTLE(XS), .LOCK_TMO(TMO), .SYNC_STAGES(2)
    ) uut (
        .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .cpu_stop_n(cpu_stop_n),
        .pci_stop_n(pci_stop_n), .vco_lock(vco_lock), .strap_pad(strap_pad),
        .strap_q(strap_q), .pad_drive_en(pad_drive_en), .xtal_en(xtal_en),
        .vco_en(vco_en), .all_clk_en(all_clk_en), .cpu_clk_en(cpu_clk_en),
        .pci_clk_en(pci_clk_en)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Advance n rising edges, then settle 3 ns (past the falling edge).
    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #3;
    endtask

    task automatic power_on(input logic [SW-1:0] pads);
        rst_n     = 1'b0;
        strap_pad = pads;
        step(2);
        check("R3 xtal in reset", xtal_en, 0);
        check("R3 vco in reset", vco_en, 0);
        check("R3 clocks in reset", {all_clk_en, cpu_clk_en, pci_clk_en}, 0);
        rst_n = 1'b1;
        check("R1 pads not driven before first edge", pad_drive_en, 0);
        step(1);
        check("R1 strap captured", strap_q, pads);
        check("R1 pads driven", pad_drive_en, 1);
        check("R11 xtal on first", {xtal_en, vco_en}, 2'b10);
        strap_pad = ~pads;
        step(XS - 1);
        check("R11 vco still off", vco_en, 0);
        step(1);
        check("R11 vco on", vco_en, 1);
        step(1);
        check("R11 clocks held in wait", all_clk_en, 0);
        step(1);
        check("R11 clocks released", {all_clk_en, cpu_clk_en, pci_clk_en}, 3'b111);
        check("R2 strap kept after pad change", strap_q, pads);
    endtask

    // From RUN: request power-down and walk down to XTAL_OFF.
    task automatic power_down;
        pd_n = 1'b0;
        step(1);
        check("R4 one edge not yet", all_clk_en, 1);
        step(1);
        check("R4 all clocks gated", {all_clk_en, cpu_clk_en, pci_clk_en}, 0);
        step(LH);
        check("R5 oscillators held during low", {vco_en, xtal_en}, 2'b11);
        step(1);
        check("R5 vco off first", {vco_en, xtal_en}, 2'b01);
        step(1);
        check("R5 xtal off second", xtal_en, 0);
    endtask

    logic [SW-1:0] kept;
    logic          prev_cpu, prev_pci;

    initial begin
        rst_n = 1'b0; pd_n = 1'b1; cpu_stop_n = 1'b1; pci_stop_n = 1'b1;
        vco_lock = 1'b1; strap_pad = '0;
        step(1);

        // Sweep every strap value through a full power-on
        for (int v = 0; v < (1 << SW); v++) begin
            power_on(SW'(v));
        end
        kept = 5'b10110;
        power_on(kept);

        // R7: stop inputs in RUN, all four combinations
        prev_cpu = 1'b1; prev_pci = 1'b1;
        for (int c = 0; c < 4; c++) begin
            cpu_stop_n = c[1];
            pci_stop_n = c[0];
            step(1);
            check("R7 stop latency one edge", {cpu_clk_en, pci_clk_en}, {prev_cpu, prev_pci});
            step(1);
            check("R7 cpu follows stop", cpu_clk_en, c[1]);
            check("R7 pci follows stop", pci_clk_en, c[0]);
            check("R7 all unaffected", all_clk_en, 1);
            prev_cpu = c[1]; prev_pci = c[0];
        end

        power_down();

        // R6: stop inputs ignored while powered down
        for (int c = 0; c < 4; c++) begin
            cpu_stop_n = c[0];
            pci_stop_n = c[1];
            step(3);
            check("R6 clocks stay low", {all_clk_en, cpu_clk_en, pci_clk_en}, 0);
        end
        cpu_stop_n = 1'b1; pci_stop_n = 1'b1;

        // Exit with no lock: timeout path
        vco_lock  = 1'b0;
        strap_pad = 5'b01001;
        step(3);
        pd_n = 1'b1;
        step(2);
        check("R8 xtal still off", xtal_en, 0);
        step(1);
        check("R8 xtal on", {xtal_en, vco_en}, 2'b10);
        step(XS - 1);
        check("R8 vco waits settle", vco_en, 0);
        step(1);
        check("R8 vco on", vco_en, 1);
        step(1);
        step(TMO - 1);
        check("R10 still waiting", all_clk_en, 0);
        step(1);
        check("R10 released on timeout", {all_clk_en, cpu_clk_en, pci_clk_en}, 3'b111);
        check("R2 strap kept after exit", strap_q, kept);

        // Exit with lock present
        power_down();
        vco_lock = 1'b1;
        pd_n     = 1'b1;
        step(3 + XS + 1);
        check("R9 held on wait entry", all_clk_en, 0);
        step(1);
        check("R9 released on lock", {all_clk_en, cpu_clk_en, pci_clk_en}, 3'b111);
        check("R2 strap kept again", strap_q, kept);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(100000 * 4);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule